// File: doc/BRIEF.md
# Tracking Coprocessor Host Slave with Frame Sequencing

This block sits between a host processor's asynchronous external-memory bus and a tracking filter datapath. The host writes bytes over an 8-bit data bus at 8-bit addresses. It qualifies each cycle with an active-low chip enable and separate write, read and output-enable strobes. Bytes are gathered into 32-bit words, least significant byte at the lowest address. A write to a launch address starts a filter frame.

On the first frame after reset the datapath is fed from the initial state, covariance and model-probability banks that the host loaded. When that frame completes, three two-way selectors switch permanently to the loop banks. Each completing frame refreshes those banks from the filter's results. Later frames need only the three spherical measurement words (range, azimuth, elevation). The filter arithmetic is outside the block: it sees a one-cycle start pulse and answers with a done pulse. The block then raises an interrupt so the host can read the filtered state back byte by byte.

Top module: `trk_hostif`

## Requirements
- R1: A byte is captured only by a write cycle with chip enable low, write strobe low, and both read and output-enable strobes high; a write strobe while either of those two is low leaves all banks unchanged.
- R2: Byte b of word w of a region is stored at region base + 4w + b and lands in bits 8b+7..8b of that word (little-endian); the regions are measurement at 0x00 (3 words), initial state at 0x10 (4 words), initial covariance at 0x20 (4 words) and initial probability at 0x30 (2 words).
- R3: A write to address 0x40 while idle produces exactly one single-cycle `flt_start_o` pulse and sets busy; a write to 0x40 while busy produces no pulse.
- R4: Until the first frame completes, `flt_state_o`, `flt_cov_o` and `flt_prob_o` present the initial banks.
- R5: `flt_done_i` while busy clears busy, sets result-ready and first-frame-done, raises `irq_o` and loads the loop banks from the result inputs.
- R6: After the first frame completes, the datapath outputs present the loop banks, and host writes to the initial regions have no effect.
- R7: Address 0x41 reads the status byte {0000, overrun[3], first_done[2], ready[1], busy[0]}; the end of a status read clears `irq_o` and overrun, and a new launch clears ready.
- R8: Measurement writes while busy are ignored and set the sticky overrun flag.
- R9: A read at 0x80 + 4w + b returns byte b of loop state word w; other unmapped or write-only addresses read 0, and `bus_rdata` is 0 unless chip enable, read and output-enable strobes are all low.
- R10: `flt_done_i` while idle is ignored: no interrupt, no status change, no loop-bank load.
- R11: After reset the status byte is 0, `irq_o` and `flt_start_o` are low, and all banks are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce_n | input | 1 | Host chip enable, active low |
| bus_we_n | input | 1 | Host write strobe, active low |
| bus_re_n | input | 1 | Host read strobe, active low |
| bus_oe_n | input | 1 | Host output enable, active low |
| bus_addr | input | 8 | Host byte address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data |
| irq_o | output | 1 | Frame-results-ready interrupt |
| flt_start_o | output | 1 | One-cycle frame launch to the filter |
| flt_done_i | input | 1 | Filter frame completion pulse |
| flt_meas_o | output | 96 | Measurement words to the filter |
| flt_state_o | output | 128 | Selected state words |
| flt_cov_o | output | 128 | Selected covariance words |
| flt_prob_o | output | 64 | Selected model-probability words |
| flt_state_res_i | input | 128 | Filtered state from the filter |
| flt_cov_res_i | input | 128 | Updated covariance from the filter |
| flt_prob_res_i | input | 64 | Updated probabilities from the filter |

## Verification
A corrupted sequencer flag shows at once in the status byte on the next host read, and in the start and interrupt pins within a few cycles of the triggering strobe. A wrong selector state shows on the datapath word outputs in the cycle after the first completion, and a lost loop-bank load shows there too and in the result bytes read back. Byte placement faults appear in the assembled measurement word after a single write cycle, about three clocks after the strobe falls.

// File: rtl/trk_hostif_pkg.sv
package trk_hostif_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = 4;

  typedef enum logic [2:0] {
    RG_NONE, RG_MEAS, RG_STATE, RG_COV, RG_PROB, RG_GO, RG_STAT, RG_RES
  } region_e;

  typedef struct packed {
    logic overrun;
    logic first_done;
    logic ready;
    logic busy;
  } status_t;
endpackage

// File: rtl/trk_strobe_sync.sv
module trk_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic re_n,
  input  logic oe_n,
  output logic wr_evt,
  output logic rd_go,
  output logic rd_end
);
  // chain index 0 is the raw input; bit order {ce, we, re, oe}
  logic [3:0] chain [STAGES+1];
  logic [3:0] prev_q;

  assign chain[0] = {ce_n, we_n, re_n, oe_n};

  for (genvar s = 1; s <= STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= 4'hF;
      else        chain[s] <= chain[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 4'hF;
    else        prev_q <= chain[STAGES];
  end

  logic [3:0] lvl;
  assign lvl = chain[STAGES];

  assign wr_evt = prev_q[2] & ~lvl[2] & ~lvl[3] & lvl[1] & lvl[0];
  assign rd_go  = prev_q[1] & ~lvl[1] & ~lvl[3];
  assign rd_end = ~prev_q[1] & lvl[1];
endmodule

// File: rtl/trk_byte_bank.sv
module trk_byte_bank
  import trk_hostif_pkg::*;
#(
  parameter int WORDS  = 4,
  parameter int WORD_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [7:0]              wr_off,
  input  logic [7:0]              wr_byte,
  input  logic                    ld_en,
  input  logic [WORDS*WORD_W-1:0] ld_word,
  output logic [WORDS*WORD_W-1:0] words_o
);
  localparam int BYTES = WORDS * (WORD_W / BYTE_W);

  logic [WORDS*WORD_W-1:0] q, nxt;

  always_comb begin
    nxt = q;
    if (ld_en)
      nxt = ld_word;
    else if (wr_en && int'(wr_off) < BYTES)
      nxt[int'(wr_off)*BYTE_W +: BYTE_W] = wr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  assign words_o = q;
endmodule

// File: rtl/trk_frame_seq.sv
module trk_frame_seq
  import trk_hostif_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    go_wr,
  input  logic    meas_blocked,
  input  logic    stat_rd_end,
  input  logic    done_i,
  output logic    start_o,
  output logic    load_o,
  output logic    irq_o,
  output status_t status_o
);
  status_t st_q;
  logic    irq_q;
  logic    launch, finish;

  assign launch = go_wr & ~st_q.busy;
  assign finish = done_i & st_q.busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= '0;
      irq_q   <= 1'b0;
      start_o <= 1'b0;
    end else begin
      start_o <= launch;
      if (launch)      st_q.busy <= 1'b1;
      else if (finish) st_q.busy <= 1'b0;
      if (launch)      st_q.ready <= 1'b0;
      else if (finish) st_q.ready <= 1'b1;
      if (finish)      st_q.first_done <= 1'b1;
      if (finish)           irq_q <= 1'b1;
      else if (stat_rd_end) irq_q <= 1'b0;
      if (meas_blocked)     st_q.overrun <= 1'b1;
      else if (stat_rd_end) st_q.overrun <= 1'b0;
    end
  end

  assign load_o   = finish;
  assign irq_o    = irq_q;
  assign status_o = st_q;
endmodule

// File: rtl/trk_hostif.sv
module trk_hostif
  import trk_hostif_pkg::*;
#(
  parameter int         WORD_W      = 32,
  parameter int         MEAS_WORDS  = 3,
  parameter int         STATE_WORDS = 4,
  parameter int         COV_WORDS   = 4,
  parameter int         PROB_WORDS  = 2,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] MEAS_BASE   = 8'h00,
  parameter logic [7:0] STATE_BASE  = 8'h10,
  parameter logic [7:0] COV_BASE    = 8'h20,
  parameter logic [7:0] PROB_BASE   = 8'h30,
  parameter logic [7:0] GO_ADDR     = 8'h40,
  parameter logic [7:0] STAT_ADDR   = 8'h41,
  parameter logic [7:0] RES_BASE    = 8'h80
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_ce_n,
  input  logic                          bus_we_n,
  input  logic                          bus_re_n,
  input  logic                          bus_oe_n,
  input  logic [7:0]                    bus_addr,
  input  logic [7:0]                    bus_wdata,
  output logic [7:0]                    bus_rdata,
  output logic                          irq_o,
  output logic                          flt_start_o,
  input  logic                          flt_done_i,
  output logic [MEAS_WORDS*WORD_W-1:0]  flt_meas_o,
  output logic [STATE_WORDS*WORD_W-1:0] flt_state_o,
  output logic [COV_WORDS*WORD_W-1:0]   flt_cov_o,
  output logic [PROB_WORDS*WORD_W-1:0]  flt_prob_o,
  input  logic [STATE_WORDS*WORD_W-1:0] flt_state_res_i,
  input  logic [COV_WORDS*WORD_W-1:0]   flt_cov_res_i,
  input  logic [PROB_WORDS*WORD_W-1:0]  flt_prob_res_i
);
  localparam int BPW         = WORD_W / BYTE_W;
  localparam int MEAS_BYTES  = MEAS_WORDS * BPW;
  localparam int STATE_BYTES = STATE_WORDS * BPW;
  localparam int COV_BYTES   = COV_WORDS * BPW;
  localparam int PROB_BYTES  = PROB_WORDS * BPW;

  function automatic logic in_win(input logic [7:0] a, input logic [7:0] base,
                                  input logic [7:0] bytes);
    logic [7:0] d;
    d = a - base;
    return d < bytes;
  endfunction

  function automatic region_e decode(input logic [7:0] a);
    if (in_win(a, MEAS_BASE, 8'(MEAS_BYTES)))   return RG_MEAS;
    if (in_win(a, STATE_BASE, 8'(STATE_BYTES))) return RG_STATE;
    if (in_win(a, COV_BASE, 8'(COV_BYTES)))     return RG_COV;
    if (in_win(a, PROB_BASE, 8'(PROB_BYTES)))   return RG_PROB;
    if (a == GO_ADDR)                           return RG_GO;
    if (a == STAT_ADDR)                         return RG_STAT;
    if (in_win(a, RES_BASE, 8'(STATE_BYTES)))   return RG_RES;
    return RG_NONE;
  endfunction

  // ---- strobe handling ----
  logic wr_evt, rd_go, rd_end;
  trk_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .ce_n(bus_ce_n), .we_n(bus_we_n), .re_n(bus_re_n), .oe_n(bus_oe_n),
    .wr_evt(wr_evt), .rd_go(rd_go), .rd_end(rd_end)
  );

  region_e rgn;
  assign rgn = decode(bus_addr);

  status_t st;
  logic    st_busy, st_ready, st_first;
  assign st_busy  = st.busy;
  assign st_ready = st.ready;
  assign st_first = st.first_done;

  logic stat_pend_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        stat_pend_q <= 1'b0;
    else if (rd_go && rgn == RG_STAT)  stat_pend_q <= 1'b1;
    else if (rd_end)                   stat_pend_q <= 1'b0;
  end

  // ---- write enables ----
  logic meas_we, init_ok, state_we, cov_we, prob_we, go_wr, meas_blk;
  assign meas_we  = wr_evt && rgn == RG_MEAS && !st.busy;
  assign meas_blk = wr_evt && rgn == RG_MEAS && st.busy;
  assign init_ok  = wr_evt && !st.busy && !st.first_done;
  assign state_we = init_ok && rgn == RG_STATE;
  assign cov_we   = init_ok && rgn == RG_COV;
  assign prob_we  = init_ok && rgn == RG_PROB;
  assign go_wr    = wr_evt && rgn == RG_GO;

  logic load;
  trk_frame_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .go_wr(go_wr), .meas_blocked(meas_blk), .stat_rd_end(rd_end & stat_pend_q),
    .done_i(flt_done_i), .start_o(flt_start_o), .load_o(load),
    .irq_o(irq_o), .status_o(st)
  );

  // ---- host-written banks ----
  logic [STATE_WORDS*WORD_W-1:0] init_state, loop_state;
  logic [COV_WORDS*WORD_W-1:0]   init_cov, loop_cov;
  logic [PROB_WORDS*WORD_W-1:0]  init_prob, loop_prob;

  trk_byte_bank #(.WORDS(MEAS_WORDS), .WORD_W(WORD_W)) u_meas (
    .clk(clk), .rst_n(rst_n), .wr_en(meas_we), .wr_off(bus_addr - MEAS_BASE),
    .wr_byte(bus_wdata), .ld_en(1'b0), .ld_word('0), .words_o(flt_meas_o));
  trk_byte_bank #(.WORDS(STATE_WORDS), .WORD_W(WORD_W)) u_init_state (
    .clk(clk), .rst_n(rst_n), .wr_en(state_we), .wr_off(bus_addr - STATE_BASE),
    .wr_byte(bus_wdata), .ld_en(1'b0), .ld_word('0), .words_o(init_state));
  trk_byte_bank #(.WORDS(COV_WORDS), .WORD_W(WORD_W)) u_init_cov (
    .clk(clk), .rst_n(rst_n), .wr_en(cov_we), .wr_off(bus_addr - COV_BASE),
    .wr_byte(bus_wdata), .ld_en(1'b0), .ld_word('0), .words_o(init_cov));
  trk_byte_bank #(.WORDS(PROB_WORDS), .WORD_W(WORD_W)) u_init_prob (
    .clk(clk), .rst_n(rst_n), .wr_en(prob_we), .wr_off(bus_addr - PROB_BASE),
    .wr_byte(bus_wdata), .ld_en(1'b0), .ld_word('0), .words_o(init_prob));

  // ---- recirculated loop banks ----
  trk_byte_bank #(.WORDS(STATE_WORDS), .WORD_W(WORD_W)) u_loop_state (
    .clk(clk), .rst_n(rst_n), .wr_en(1'b0), .wr_off(8'h00), .wr_byte(8'h00),
    .ld_en(load), .ld_word(flt_state_res_i), .words_o(loop_state));
  trk_byte_bank #(.WORDS(COV_WORDS), .WORD_W(WORD_W)) u_loop_cov (
    .clk(clk), .rst_n(rst_n), .wr_en(1'b0), .wr_off(8'h00), .wr_byte(8'h00),
    .ld_en(load), .ld_word(flt_cov_res_i), .words_o(loop_cov));
  trk_byte_bank #(.WORDS(PROB_WORDS), .WORD_W(WORD_W)) u_loop_prob (
    .clk(clk), .rst_n(rst_n), .wr_en(1'b0), .wr_off(8'h00), .wr_byte(8'h00),
    .ld_en(load), .ld_word(flt_prob_res_i), .words_o(loop_prob));

  // ---- initial / loop selectors ----
  assign flt_state_o = st.first_done ? loop_state : init_state;
  assign flt_cov_o   = st.first_done ? loop_cov   : init_cov;
  assign flt_prob_o  = st.first_done ? loop_prob  : init_prob;

  // ---- read path ----
  logic [7:0] res_off;
  assign res_off = bus_addr - RES_BASE;

  always_comb begin
    bus_rdata = 8'h00;
    if (!bus_ce_n && !bus_re_n && !bus_oe_n) begin
      if (rgn == RG_STAT)
        bus_rdata = {4'h0, st};
      else if (rgn == RG_RES)
        bus_rdata = loop_state[int'(res_off)*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/trk_hostif_chk.sv
module trk_hostif_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic done,
  input logic irq,
  input logic busy,
  input logic ready,
  input logic first_done
);
  p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> busy);
  p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(done) && $past(busy));
  p_finish_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && busy) |=> ready && first_done && !busy && irq);
  p_first_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    first_done |=> first_done);
  p_idle_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !busy) |=> $stable(ready) && $stable(first_done));
endmodule

bind trk_hostif trk_hostif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(flt_start_o), .done(flt_done_i),
  .irq(irq_o), .busy(st_busy), .ready(st_ready), .first_done(st_first)
);

// File: tb/trk_hostif_bench.sv
module trk_hostif_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, re_n = 1'b1, oe_n = 1'b1;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic irq, start, done = 1'b0;
  logic [95:0]  meas;
  logic [127:0] state_o, cov_o, state_res = '0, cov_res = '0;
  logic [63:0]  prob_o, prob_res = '0;

  int checks = 0, failures = 0, starts = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  trk_hostif u_trk_hostif (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_we_n(we_n), .bus_re_n(re_n),
    .bus_oe_n(oe_n), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .irq_o(irq), .flt_start_o(start), .flt_done_i(done), .flt_meas_o(meas),
    .flt_state_o(state_o), .flt_cov_o(cov_o), .flt_prob_o(prob_o),
    .flt_state_res_i(state_res), .flt_cov_res_i(cov_res), .flt_prob_res_i(prob_res)
  );

  always @(posedge clk) if (rst_n && start) starts++;

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // scoreboard for host reads
  logic [7:0] exp_q[$];
  string      tag_q[$];
  event       smp_ev;
  initial forever begin
    @(smp_ev);
    #1;
    chk(tag_q.pop_front(), 128'(rdata), 128'(exp_q.pop_front()));
  end

  task automatic bus_write(logic [7:0] a, logic [7:0] d, bit oe_low = 0);
    @(negedge clk);
    addr = a; wdata = d; ce_n = 0; re_n = 1; oe_n = oe_low ? 1'b0 : 1'b1; we_n = 0;
    repeat (4) @(negedge clk);
    we_n = 1; ce_n = 1; oe_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic write_word(logic [7:0] a, logic [31:0] w);
    for (int b = 0; b < 4; b++) bus_write(a + 8'(b), w[8*b +: 8]);
  endtask

  task automatic bus_read(logic [7:0] a, logic [7:0] e, string tag);
    @(negedge clk);
    addr = a; ce_n = 0; oe_n = 0; re_n = 0;
    repeat (4) @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    -> smp_ev;
    @(negedge clk);
    re_n = 1; oe_n = 1; ce_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1;
    @(negedge clk); done = 0;
    repeat (2) @(negedge clk);
  endtask

  logic [31:0] mv[3]  = '{32'h11223344, 32'hA5A55A5A, 32'h0BADF00D};
  logic [31:0] sv[4]  = '{32'h01010101, 32'h02020304, 32'h30405060, 32'hCAFEBABE};
  logic [31:0] cv[4]  = '{32'h10000001, 32'h20000002, 32'h30000003, 32'h40000004};
  logic [31:0] pv[2]  = '{32'h3F000000, 32'h3F000001};

  initial begin
    logic [95:0]  m_exp;
    logic [127:0] s_exp, c_exp;
    logic [63:0]  p_exp;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R11 reset state
    chk("R11 irq", 128'(irq), 0);
    chk("R11 start", 128'(start), 0);
    chk("R11 meas", 128'(meas), 0);
    bus_read(8'h41, 8'h00, "R11 status");

    // R1 write with output enable low has no effect
    bus_write(8'h00, 8'hAA, 1);
    chk("R1 oe-low write ignored", 128'(meas), 0);
    // R9 no read cycle -> rdata zero
    addr = 8'h41;
    #1 chk("R9 idle rdata", 128'(rdata), 0);

    // R2 little-endian assembly
    for (int w = 0; w < 3; w++) write_word(8'h00 + 8'(4*w), mv[w]);
    m_exp = {mv[2], mv[1], mv[0]};
    chk("R2 meas words", 128'(meas), 128'(m_exp));
    for (int w = 0; w < 4; w++) write_word(8'h10 + 8'(4*w), sv[w]);
    for (int w = 0; w < 4; w++) write_word(8'h20 + 8'(4*w), cv[w]);
    for (int w = 0; w < 2; w++) write_word(8'h30 + 8'(4*w), pv[w]);
    s_exp = {sv[3], sv[2], sv[1], sv[0]};
    c_exp = {cv[3], cv[2], cv[1], cv[0]};
    p_exp = {pv[1], pv[0]};
    chk("R4 state init", state_o, s_exp);
    chk("R4 cov init", cov_o, c_exp);
    chk("R4 prob init", 128'(prob_o), 128'(p_exp));

    // R10 done while idle
    state_res = ~s_exp;
    pulse_done();
    chk("R10 irq stays low", 128'(irq), 0);
    chk("R10 no loop load", state_o, s_exp);
    bus_read(8'h41, 8'h00, "R10 status");

    // R3 launch
    bus_write(8'h40, 8'h01);
    chk("R3 one start", 128'(starts), 1);
    bus_read(8'h41, 8'h01, "R3 busy");

    // R8 measurement write while busy
    bus_write(8'h00, 8'hEE);
    chk("R8 meas unchanged", 128'(meas), 128'(m_exp));
    bus_read(8'h41, 8'h09, "R8 overrun");
    bus_read(8'h41, 8'h01, "R7 overrun cleared");

    // R3 go while busy
    bus_write(8'h40, 8'h01);
    chk("R3 no start while busy", 128'(starts), 1);

    // R5 completion
    state_res = 128'h0F0E0D0C_0B0A0908_07060504_03020100;
    cov_res   = 128'h99999999_88888888_77777777_66666666;
    prob_res  = 64'h3F7D70A4_3C23D70A;
    pulse_done();
    chk("R5 irq", 128'(irq), 1);
    chk("R6 state loop", state_o, state_res);
    chk("R6 cov loop", cov_o, cov_res);
    chk("R6 prob loop", 128'(prob_o), 128'(prob_res));
    bus_read(8'h41, 8'h06, "R5 status");
    chk("R7 irq cleared", 128'(irq), 0);

    // R9 result readback
    bus_read(8'h86, 8'h06, "R9 word1 byte2");
    bus_read(8'h8C, 8'h0C, "R9 word3 byte0");
    bus_read(8'h8F, 8'h0F, "R9 word3 byte3");
    bus_read(8'h10, 8'h00, "R9 init region reads zero");
    bus_read(8'h50, 8'h00, "R9 unmapped");

    // R6 init writes ignored after first frame
    write_word(8'h10, 32'hDEADBEEF);
    chk("R6 init write ignored", state_o, 128'h0F0E0D0C_0B0A0908_07060504_03020100);

    // frame two: measurements only
    write_word(8'h04, 32'h12345678);
    m_exp[63:32] = 32'h12345678;
    chk("R2 frame2 meas", 128'(meas), 128'(m_exp));
    bus_write(8'h40, 8'h01);
    chk("R3 second start", 128'(starts), 2);
    bus_read(8'h41, 8'h05, "R7 ready cleared on launch");
    state_res = 128'hFFEEDDCC_BBAA9988_77665544_33221100;
    pulse_done();
    chk("R5 irq frame2", 128'(irq), 1);
    chk("R5 loop reload", state_o, state_res);
    bus_read(8'h81, 8'h11, "R9 frame2 byte");
    bus_read(8'h41, 8'h06, "R7 status frame2");
    chk("R7 irq cleared frame2", 128'(irq), 0);

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule